// File: doc/BRIEF.md
# Word-Granular Data Filter Cache

A 512-byte cache placed between the load/store pipeline and a single-cycle first-level data cache. It cuts the number of L1 accesses. When a load misses, the block fetches only the single 32-bit word that was referenced and writes it into its line. The rest of that line stays empty until those words are used. Each of the 16 direct-mapped lines keeps two tags. Every word slot records which of the two tags it belongs to, so one line can hold words from two different L1 lines at the same time.

The hit check runs one stage early, during the execute stage. It uses the base register as the address, so it does not wait for the address adder. If adding the offset leaves the 32-byte line unchanged, and the referenced word is present under its tag, the memory stage reads the data array and skips the L1. In every other case the memory stage sends the access to the L1. The L1 answers in the same cycle, so a load result appears in the memory stage every time, with no stall. Stores always write through to the L1. A store updates its word in this cache only when that word is already present.

Top module: `wordfill_cache`

## Requirements
- R1: While reset is held and right after it, no load result and no L1 request are produced, and every word slot is empty, so the first load of any address misses.
- R2: A load presented in one cycle produces `ld_valid` in the next cycle. On a miss, that cycle carries an L1 read (`l1_req_we`=0, all byte enables set) of the effective address, and `ld_data` equals `l1_rsp_data` of that same cycle.
- R3: A miss fills only the referenced word. A later load of another word in the same 32-byte line misses.
- R4: A load whose early check succeeds raises `ld_hit`, issues no L1 request, and returns the current memory value from the local array.
- R5: Words from two address lines that share a line index (address bits [8:5]) but differ in tag (bits [31:9]) can reside together, and both hit.
- R6: A fill whose tag matches neither stored tag replaces the least recently used tag of that line. All words held under the replaced tag become empty, and words under the other tag keep hitting.
- R7: The early check uses the base address. If base+offset falls in a different 32-byte line than base (bits [31:5] differ), the load misses even when the word is present. Negative offsets within the line can hit.
- R8: A load checked in the same cycle that a missing load fills the same line index is treated as a miss.
- R9: Each store produces, in the next cycle, exactly one L1 write with its effective address, byte enables and data, and no load result.
- R10: A store to a present word merges its enabled bytes into that word, and the word stays present. A following load hits and returns the merged value.
- R11: A store to a word that is not present never allocates it. A later load of that word misses.
- R12: For every load exactly one of `ld_hit` and `ld_miss` is high. Both are low when no load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access presented in execute stage |
| req_store | input | 1 | 1 = store, 0 = load |
| req_base | input | 32 | Base register value |
| req_offset | input | 32 | Address offset (two's complement) |
| req_be | input | 4 | Store byte enables |
| req_wdata | input | 32 | Store data |
| l1_rsp_data | input | 32 | Word returned by the L1 in the request cycle |
| ld_valid | output | 1 | Load result valid (memory stage) |
| ld_data | output | 32 | Load result |
| ld_hit | output | 1 | Load served locally |
| ld_miss | output | 1 | Load served by the L1 |
| l1_req_valid | output | 1 | L1 access this cycle |
| l1_req_we | output | 1 | L1 write |
| l1_req_addr | output | 32 | L1 byte address |
| l1_req_be | output | 4 | L1 byte enables |
| l1_req_wdata | output | 32 | L1 write data |

## Verification
The situations hardest to reach from the ports involve state that the early check cannot see. One is a load checked while the previous load is still writing its fill into the same line. Another is a word that is present but reached through a base register in a neighbouring line. The bench builds these directly: back-to-back loads to one index, a base one word below the line with a positive offset, and a base inside the line with a negative offset. A long random phase then follows. It mixes loads, stores and idle cycles over four tags and four indices, so that eviction, packing and fill conflicts arise often, and a behavioural model predicts hit or miss for every load.

// File: rtl/wordfill_pkg.sv
package wordfill_pkg;
    parameter int ADDR_W     = 32;
    parameter int DATA_W     = 32;
    parameter int CAP_BYTES  = 512;
    parameter int LINE_BYTES = 32;

    localparam int BE_W     = DATA_W / 8;
    localparam int WORDS    = LINE_BYTES / BE_W;
    localparam int LINES    = CAP_BYTES / LINE_BYTES;
    localparam int BOFF_W   = $clog2(BE_W);
    localparam int WSEL_W   = $clog2(WORDS);
    localparam int IDX_W    = $clog2(LINES);
    localparam int LINE_LSB = BOFF_W + WSEL_W;
    localparam int TAG_W    = ADDR_W - LINE_LSB - IDX_W;
    // two tag registers per line, so the owner selector is one bit
    localparam int SLOTS    = 2;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [BOFF_W-1:0] boff_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [BE_W-1:0]   be_t;
    typedef logic              slot_t;

    typedef struct packed {
        tag_t  tag;
        idx_t  idx;
        wsel_t word;
        boff_t boff;
    } addr_t;

    typedef struct packed {
        logic  valid;
        logic  store;
        addr_t addr;
        be_t   be;
        word_t wdata;
        logic  spec_hit;
    } mstage_t;
endpackage

// File: rtl/wordfill_spec.sv
module wordfill_spec
    import wordfill_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    output tag_t              look_tag,
    output idx_t              look_idx,
    output wsel_t             look_word,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              line_same
);
    logic [ADDR_W-1:0] sum;

    always_comb begin
        sum       = base + offset;
        eff_addr  = sum;
        // tag and index come from the base register; only the word bits
        // of the sum are used, and line_same tells whether that is valid
        look_tag  = base[ADDR_W-1 -: TAG_W];
        look_idx  = base[LINE_LSB +: IDX_W];
        look_word = sum[BOFF_W +: WSEL_W];
        line_same = (sum[ADDR_W-1:LINE_LSB] == base[ADDR_W-1:LINE_LSB]);
    end
endmodule

// File: rtl/wordfill_tags.sv
module wordfill_tags
    import wordfill_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  tag_t  spec_tag,
    input  idx_t  spec_idx,
    input  wsel_t spec_word,
    output logic  spec_resident,
    input  tag_t  mem_tag,
    input  idx_t  mem_idx,
    input  wsel_t mem_word,
    output logic  mem_resident,
    input  logic  fill_en,
    input  logic  touch_en
);
    typedef struct packed {
        logic [LINES-1:0][SLOTS-1:0][TAG_W-1:0] tag;
        logic [LINES-1:0][SLOTS-1:0]            tvld;
        logic [LINES-1:0]                       lru;
        logic [LINES-1:0][WORDS-1:0]            wvld;
        logic [LINES-1:0][WORDS-1:0]            wsel;
    } tstate_t;

    tstate_t st_q, st_d;
    logic    match_any, free_any;
    slot_t   match_slot, free_slot, victim;

    function automatic logic probe(tstate_t s, tag_t t, idx_t i, wsel_t w);
        slot_t k;
        k = s.wsel[i][w];
        return s.wvld[i][w] && s.tvld[i][k] && (s.tag[i][k] == t);
    endfunction

    always_comb begin
        spec_resident = probe(st_q, spec_tag, spec_idx, spec_word);
        mem_resident  = probe(st_q, mem_tag, mem_idx, mem_word);

        match_any  = 1'b0;
        match_slot = 1'b0;
        free_any   = 1'b0;
        free_slot  = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            if (st_q.tvld[mem_idx][k] && (st_q.tag[mem_idx][k] == mem_tag) && !match_any) begin
                match_any  = 1'b1;
                match_slot = slot_t'(k);
            end
            if (!st_q.tvld[mem_idx][k] && !free_any) begin
                free_any  = 1'b1;
                free_slot = slot_t'(k);
            end
        end
        victim = match_any ? match_slot : (free_any ? free_slot : st_q.lru[mem_idx]);

        st_d = st_q;
        if (touch_en) begin
            st_d.lru[mem_idx] = ~st_q.wsel[mem_idx][mem_word];
        end
        if (fill_en) begin
            if (!match_any) begin
                st_d.tag[mem_idx][victim]  = mem_tag;
                st_d.tvld[mem_idx][victim] = 1'b1;
                for (int w = 0; w < WORDS; w++) begin
                    if (st_q.wsel[mem_idx][w] == victim) begin
                        st_d.wvld[mem_idx][w] = 1'b0;
                    end
                end
            end
            st_d.wvld[mem_idx][mem_word] = 1'b1;
            st_d.wsel[mem_idx][mem_word] = victim;
            st_d.lru[mem_idx]            = ~victim;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wordfill_data.sv
module wordfill_data
    import wordfill_pkg::*;
(
    input  logic  clk,
    input  logic  rd_en,
    input  idx_t  rd_idx,
    input  wsel_t rd_word,
    output word_t rd_data,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  wsel_t wr_word,
    input  be_t   wr_be,
    input  word_t wr_data
);
    word_t mem_q [LINES][WORDS];

    always_comb begin
        rd_data = rd_en ? mem_q[rd_idx][rd_word] : '0;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[b]) begin
                    mem_q[wr_idx][wr_word][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/wordfill_cache.sv
module wordfill_cache
    import wordfill_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] l1_rsp_data,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_hit,
    output logic              ld_miss,
    output logic              l1_req_valid,
    output logic              l1_req_we,
    output logic [ADDR_W-1:0] l1_req_addr,
    output logic [BE_W-1:0]   l1_req_be,
    output logic [DATA_W-1:0] l1_req_wdata
);
    tag_t              look_tag;
    idx_t              look_idx;
    wsel_t             look_word;
    logic [ADDR_W-1:0] eff_addr;
    logic              line_same;
    logic              spec_resident, mem_resident;
    logic              fill_en, touch_en, store_upd, fill_conflict;
    logic              arr_wr_en;
    be_t               arr_wr_be;
    word_t             arr_wr_data, arr_rd_data;
    mstage_t           mem_q, mem_d;

    wordfill_spec u_spec (
        .base      (req_base),
        .offset    (req_offset),
        .look_tag  (look_tag),
        .look_idx  (look_idx),
        .look_word (look_word),
        .eff_addr  (eff_addr),
        .line_same (line_same)
    );

    wordfill_tags u_tags (
        .clk           (clk),
        .rst_n         (rst_n),
        .spec_tag      (look_tag),
        .spec_idx      (look_idx),
        .spec_word     (look_word),
        .spec_resident (spec_resident),
        .mem_tag       (mem_q.addr.tag),
        .mem_idx       (mem_q.addr.idx),
        .mem_word      (mem_q.addr.word),
        .mem_resident  (mem_resident),
        .fill_en       (fill_en),
        .touch_en      (touch_en)
    );

    wordfill_data u_data (
        .clk     (clk),
        .rd_en   (touch_en),
        .rd_idx  (mem_q.addr.idx),
        .rd_word (mem_q.addr.word),
        .rd_data (arr_rd_data),
        .wr_en   (arr_wr_en),
        .wr_idx  (mem_q.addr.idx),
        .wr_word (mem_q.addr.word),
        .wr_be   (arr_wr_be),
        .wr_data (arr_wr_data)
    );

    // memory stage
    always_comb begin
        ld_valid  = mem_q.valid && !mem_q.store;
        touch_en  = ld_valid && mem_q.spec_hit;
        fill_en   = ld_valid && !mem_q.spec_hit;
        store_upd = mem_q.valid && mem_q.store && mem_resident;
        ld_hit    = touch_en;
        ld_miss   = fill_en;
        ld_data   = touch_en ? arr_rd_data : l1_rsp_data;

        l1_req_valid = mem_q.valid && (mem_q.store || !mem_q.spec_hit);
        l1_req_we    = mem_q.valid && mem_q.store;
        l1_req_addr  = mem_q.addr;
        l1_req_be    = mem_q.store ? mem_q.be : '1;
        l1_req_wdata = mem_q.wdata;

        arr_wr_en   = fill_en || store_upd;
        arr_wr_be   = fill_en ? '1 : mem_q.be;
        arr_wr_data = fill_en ? l1_rsp_data : mem_q.wdata;
    end

    // execute stage: early check against state not yet updated by this cycle's fill
    always_comb begin
        fill_conflict = fill_en && (mem_q.addr.idx == look_idx);
        mem_d.valid    = req_valid;
        mem_d.store    = req_store;
        mem_d.addr     = addr_t'(eff_addr);
        mem_d.be       = req_be;
        mem_d.wdata    = req_wdata;
        mem_d.spec_hit = req_valid && !req_store && line_same && spec_resident && !fill_conflict;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/wordfill_cache_checker.sv
module wordfill_cache_checker
    import wordfill_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_store,
    input logic [ADDR_W-1:0] req_base,
    input logic [ADDR_W-1:0] req_offset,
    input logic              ld_valid,
    input logic              ld_hit,
    input logic              ld_miss,
    input logic              l1_req_valid,
    input logic              l1_req_we
);
    logic line_same_w;
    assign line_same_w = ((req_base + req_offset) >> LINE_LSB) == (req_base >> LINE_LSB);

    a_r2_load_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_store |=> ld_valid && !l1_req_we);

    a_r2_miss_reads_l1: assert property (@(posedge clk) disable iff (!rst_n)
        ld_miss |-> l1_req_valid && !l1_req_we);

    a_r4_hit_skips_l1: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit |-> !l1_req_valid);

    a_r7_hit_needs_same_line: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit |-> $past(line_same_w));

    a_r9_store_write_through: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_store |=> l1_req_valid && l1_req_we && !ld_valid);

    a_r12_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $countones({ld_hit, ld_miss}) == 1);

    a_r12_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> !ld_hit && !ld_miss);
endmodule

bind wordfill_cache wordfill_cache_checker u_chk (.*);

// File: tb/wordfill_cache_bench.sv
module wordfill_cache_bench;
    import wordfill_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_OPS   = 4000;
    localparam int TAG_SHIFT  = LINE_LSB + IDX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0;
    logic [31:0] req_base = '0, req_offset = '0, req_wdata = '0, l1_rsp_data = '0;
    logic [3:0]  req_be = '0;
    logic        ld_valid, ld_hit, ld_miss, l1_req_valid, l1_req_we;
    logic [31:0] ld_data, l1_req_addr, l1_req_wdata;
    logic [3:0]  l1_req_be;

    always #(CLK_PERIOD/2) clk = ~clk;

    wordfill_cache u_wordfill_cache (
        .clk, .rst_n, .req_valid, .req_store, .req_base, .req_offset, .req_be,
        .req_wdata, .l1_rsp_data, .ld_valid, .ld_data, .ld_hit, .ld_miss,
        .l1_req_valid, .l1_req_we, .l1_req_addr, .l1_req_be, .l1_req_wdata
    );

    typedef struct {
        bit          valid;
        bit          store;
        logic [31:0] base;
        logic [31:0] off;
        logic [31:0] ea;
        logic [3:0]  be;
        logic [31:0] wdata;
        bit          pred;
        string       req;
    } op_t;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] gmem [logic [31:0]];
    logic [31:0] slot_wa [LINES][WORDS];
    bit          slot_v  [LINES][WORDS];
    logic [31:0] mru_t [LINES];
    logic [31:0] lru_t [LINES];
    int          ntag  [LINES];
    op_t         cur;

    function automatic logic [31:0] gold(logic [31:0] wa);
        if (gmem.exists(wa)) return gmem[wa];
        return (wa * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
    endfunction

    function automatic int idx_of(logic [31:0] a);
        return int'((a >> LINE_LSB) % LINES);
    endfunction

    function automatic int word_of(logic [31:0] a);
        return int'((a >> BOFF_W) % WORDS);
    endfunction

    function automatic bit resident(logic [31:0] a);
        return slot_v[idx_of(a)][word_of(a)] && (slot_wa[idx_of(a)][word_of(a)] == (a >> BOFF_W));
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // recency bookkeeping of the two line owners
    task automatic use_tag(int i, logic [31:0] t);
        if (ntag[i] >= 1 && mru_t[i] == t) return;
        if (ntag[i] == 2 && lru_t[i] == t) begin
            lru_t[i] = mru_t[i];
            mru_t[i] = t;
            return;
        end
        if (ntag[i] == 2) begin
            for (int w = 0; w < WORDS; w++)
                if (slot_v[i][w] && ((slot_wa[i][w] << BOFF_W) >> TAG_SHIFT) == lru_t[i])
                    slot_v[i][w] = 1'b0;
        end
        if (ntag[i] >= 1) lru_t[i] = mru_t[i];
        mru_t[i] = t;
        if (ntag[i] < 2) ntag[i]++;
    endtask

    task automatic apply(op_t o);
        logic [31:0] v;
        if (!o.valid) return;
        if (o.store) begin
            v = gold(o.ea >> BOFF_W);
            for (int b = 0; b < 4; b++)
                if (o.be[b]) v[b*8 +: 8] = o.wdata[b*8 +: 8];
            gmem[o.ea >> BOFF_W] = v;
        end else begin
            use_tag(idx_of(o.ea), o.ea >> TAG_SHIFT);
            if (!o.pred) begin
                slot_wa[idx_of(o.ea)][word_of(o.ea)] = o.ea >> BOFF_W;
                slot_v[idx_of(o.ea)][word_of(o.ea)]  = 1'b1;
            end
        end
    endtask

    task automatic check_mem(op_t o);
        if (!o.valid) begin
            chk("R1", "idle ld_valid", {31'b0, ld_valid}, 32'd0);
            chk("R1", "idle l1_req_valid", {31'b0, l1_req_valid}, 32'd0);
        end else if (o.store) begin
            chk("R9", "store l1_req_valid", {31'b0, l1_req_valid}, 32'd1);
            chk("R9", "store l1_req_we", {31'b0, l1_req_we}, 32'd1);
            chk("R9", "store addr", l1_req_addr, o.ea);
            chk("R9", "store be", {28'b0, l1_req_be}, {28'b0, o.be});
            chk("R9", "store data", l1_req_wdata, o.wdata);
            chk("R12", "store status", {29'b0, ld_valid, ld_hit, ld_miss}, 32'd0);
        end else begin
            chk("R2", "ld_valid", {31'b0, ld_valid}, 32'd1);
            chk(o.req, "ld_hit", {31'b0, ld_hit}, {31'b0, o.pred});
            chk("R12", "ld_miss", {31'b0, ld_miss}, {31'b0, !o.pred});
            chk(o.req, "ld_data", ld_data, gold(o.ea >> BOFF_W));
            chk("R4", "l1_req_valid", {31'b0, l1_req_valid}, {31'b0, !o.pred});
            if (!o.pred) begin
                chk("R2", "miss addr", l1_req_addr, o.ea);
                chk("R2", "miss we", {31'b0, l1_req_we}, 32'd0);
                chk("R2", "miss be", {28'b0, l1_req_be}, 32'hF);
            end
        end
    endtask

    task automatic step(op_t n);
        bit conflict;
        @(posedge clk);
        #1;
        l1_rsp_data = (cur.valid && !cur.store) ? gold(cur.ea >> BOFF_W) : 32'h0;
        @(negedge clk);
        check_mem(cur);
        apply(cur);
        n.ea = n.base + n.off;
        conflict = cur.valid && !cur.store && !cur.pred && (idx_of(cur.ea) == idx_of(n.ea));
        n.pred = n.valid && !n.store && ((n.base >> LINE_LSB) == (n.ea >> LINE_LSB))
                 && !conflict && resident(n.ea);
        req_valid  = n.valid;
        req_store  = n.store;
        req_base   = n.base;
        req_offset = n.off;
        req_be     = n.be;
        req_wdata  = n.wdata;
        cur = n;
    endtask

    task automatic ld(logic [31:0] b, logic [31:0] o, string r);
        op_t n;
        n.valid = 1; n.store = 0; n.base = b; n.off = o; n.be = 4'h0; n.wdata = '0; n.req = r;
        step(n);
    endtask

    task automatic st(logic [31:0] b, logic [31:0] o, logic [3:0] be, logic [31:0] d, string r);
        op_t n;
        n.valid = 1; n.store = 1; n.base = b; n.off = o; n.be = be; n.wdata = d; n.req = r;
        step(n);
    endtask

    task automatic idle();
        op_t n;
        n.valid = 0; n.store = 0; n.base = '0; n.off = '0; n.be = '0; n.wdata = '0; n.req = "R1";
        step(n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin
            ntag[i] = 0;
            mru_t[i] = '0;
            lru_t[i] = '0;
            for (int w = 0; w < WORDS; w++) begin
                slot_v[i][w] = 1'b0;
                slot_wa[i][w] = '0;
            end
        end
        cur.valid = 0; cur.store = 0; cur.base = '0; cur.off = '0; cur.ea = '0;
        cur.be = '0; cur.wdata = '0; cur.pred = 0; cur.req = "R1";

        repeat (3) @(negedge clk);
        chk("R1", "reset ld_valid", {31'b0, ld_valid}, 32'd0);
        chk("R1", "reset l1_req_valid", {31'b0, l1_req_valid}, 32'd0);
        chk("R1", "reset status", {30'b0, ld_hit, ld_miss}, 32'd0);
        rst_n = 1'b1;

        idle();
        ld(32'h1000, 0, "R1");
        idle();
        ld(32'h1000, 0, "R4");
        ld(32'h1004, 0, "R3");
        idle();
        ld(32'h1008, 0, "R8");
        ld(32'h1008, 0, "R8");
        idle();
        ld(32'h1008, 0, "R4");
        ld(32'h120C, 0, "R5");
        idle();
        ld(32'h120C, 0, "R5");
        ld(32'h1000, 0, "R5");
        ld(32'h1414, 0, "R6");
        idle();
        ld(32'h1000, 0, "R6");
        ld(32'h120C, 0, "R6");
        ld(32'h1020, 0, "R7");
        idle();
        ld(32'h101C, 32'd4, "R7");
        idle();
        ld(32'h1024, 32'hFFFF_FFFC, "R7");
        st(32'h1040, 0, 4'b0011, 32'hDEAD_BEEF, "R11");
        idle();
        ld(32'h1040, 0, "R11");
        st(32'h1000, 0, 4'b1100, 32'h1234_5678, "R10");
        ld(32'h1000, 0, "R10");
        idle();

        for (int k = 0; k < RAND_OPS; k++) begin
            int          r;
            logic [31:0] ea, off;
            r   = int'($urandom % 10);
            ea  = 32'h2000 + (($urandom % 4) << 9) + (($urandom % 4) << 5) + (($urandom % 8) << 2);
            off = ($urandom % 3 == 0) ? 32'h0 : (($urandom % 16) * 4) - 32'd32;
            if (r < 2) idle();
            else if (r < 5) st(ea - off, off, 4'($urandom % 16), $urandom, "R10");
            else ld(ea - off, off, "R12");
        end
        idle();
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule